// File: doc/BRIEF.md
# Data-Enable Frame Position Decoder

This block sits behind the receiver of a video link that carries only a pixel clock, a data-enable strobe and pixel data, with no horizontal or vertical sync. From the data-enable input alone it produces the column and line of the pixel currently on the link. It also flags positions that must be painted black, and it pulses once at the top-left pixel of every frame.

The top of a frame is found by timing how long data-enable stays low. A rise of data-enable that ends a low stretch of at least `GAP_LINES` line periods starts a new frame. The line period used for that test is the rise-to-rise distance of the most recent ordinary line. Until one has been measured, the nominal period `H_NOMINAL` is used instead.

Two cases are padded with black so that downstream logic always sees a full raster:
- A line whose data-enable pulse is shorter than `H_ACTIVE` clocks is padded to the nominal width.
- A frame that stops sending lines early is completed with synthetic lines, one per measured line period, up to line `V_ACTIVE-1`.

The reset input is asynchronous and active low. Its release is expected to be synchronized to `clk` upstream.

Top module: `dfd_frame_locator`

## Requirements
- R1: On the first clock with `data_en` high after a rise, `pix_x` is 0. While `data_en` stays high, `pix_x` grows by one per clock and holds at `H_ACTIVE-1`. Positions are zero-based.
- R2: A rise of `data_en` that follows a low stretch of at least `GAP_LINES` times the line period starts a frame. In that same clock `frame_start` is high for one clock, `pix_valid` is high, and `pix_x` and `pix_y` are both 0.
- R3: A line may end before `H_ACTIVE` clocks of `data_en`. From the clock `data_en` falls until column `H_ACTIVE-1` has passed, `fill_black` is high, `pix_x` keeps counting, and `pix_valid` is low. `fill_black` and `pix_valid` are never high together.
- R4: Inside a frame, the next rise may fail to arrive exactly one line period after the previous line start while `data_en` is low. A synthetic line then begins at that clock. `pix_y` advances, `pix_x` restarts at 0, and `fill_black` is high for columns 0 to `H_ACTIVE-1`. Synthetic lines repeat each line period until line `V_ACTIVE-1` has been produced.
- R5: The line period is the number of clocks between the two most recent consecutive real line starts, excluding frame-starting rises. After reset and until the first measurement, `H_NOMINAL` is used.
- R6: Each further rise inside a frame advances `pix_y` by one. Rises beyond line `V_ACTIVE-1` give neither `pix_valid` nor `fill_black`, and `pix_y` holds `V_ACTIVE-1`.
- R7: A low stretch shorter than the threshold does not start a frame and does not pulse `frame_start`.
- R8: During reset and after it, `pix_valid`, `fill_black` and `frame_start` stay low, whatever `data_en` does, until the first qualifying frame start.
- R9: Driving `rst_n` low forces `pix_valid`, `fill_black` and `frame_start` low at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| data_en | input | 1 | Data-enable strobe from the link |
| pix_x | output | $clog2(H_ACTIVE) | Column of the current clock, zero-based |
| pix_y | output | $clog2(V_ACTIVE) | Line of the current clock, zero-based |
| pix_valid | output | 1 | Current clock carries an active pixel inside the raster |
| fill_black | output | 1 | Current raster position has no data and is to be shown black |
| frame_start | output | 1 | One-clock pulse on the top-left pixel of a frame |

## Verification
The bench uses a small raster of 16 columns, 6 lines and a 24-clock nominal period. It drives the following patterns:
- Regular lines before any frame lock, to show the outputs stay quiet.
- A long gap followed by full frames, with extra lines beyond the last row.
- A gap just short of the threshold, which separates a real frame start from a false one.
- A frame containing a truncated data-enable pulse.
- A frame that stops after three lines, which shows the synthetic black lines.
- Lines with a shorter 20-clock period, followed by a gap that qualifies only against the measured period and not the nominal one. This separates the measured period from the fallback.

A reset pulse in the middle of a line checks that the outputs clear at once, and that the decoder returns to waiting for a new frame gap.

// File: rtl/dfd_pkg.sv
package dfd_pkg;

  // Kind of line start seen in the current clock
  typedef enum logic [1:0] {
    LS_NONE = 2'd0,
    LS_REAL = 2'd1,
    LS_TOP  = 2'd2,
    LS_VIRT = 2'd3
  } line_start_e;

endpackage

// File: rtl/dfd_origin_detect.sv
module dfd_origin_detect #(
  parameter int LINE_W    = 12,
  parameter int GAP_LINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic [LINE_W-1:0] hper,
  output logic              rise,
  output logic              top
);

  localparam int LOW_W = LINE_W + $clog2(GAP_LINES + 1);
  localparam logic [LOW_W-1:0] LOW_MAX = {LOW_W{1'b1}};
  localparam logic [LOW_W-1:0] GAP_K   = LOW_W'(GAP_LINES);

  logic             de_q;
  logic [LOW_W-1:0] low_q, low_d, thresh;

  // Low-run length and frame-gap qualification
  always_comb begin
    rise   = de & ~de_q;
    thresh = GAP_K * LOW_W'(hper);
    top    = rise & (low_q >= thresh);
    if (de)
      low_d = '0;
    else if (low_q == LOW_MAX)
      low_d = low_q;
    else
      low_d = low_q + LOW_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      low_q <= '0;
    end else begin
      de_q  <= de;
      low_q <= low_d;
    end
  end

endmodule

// File: rtl/dfd_period_meter.sv
module dfd_period_meter
  import dfd_pkg::*;
#(
  parameter int LINE_W    = 12,
  parameter int H_NOMINAL = 1100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_start_e       start,
  output logic [LINE_W-1:0] since,
  output logic [LINE_W-1:0] hper
);

  localparam logic [LINE_W-1:0] SINCE_MAX = {LINE_W{1'b1}};
  localparam logic [LINE_W-1:0] HPER_RST  = LINE_W'(H_NOMINAL);

  logic [LINE_W-1:0] since_q, since_d, hper_q, hper_d;
  logic              prev_real_q, prev_real_d, hper_en;

  always_comb begin
    if (start != LS_NONE)
      since_d = LINE_W'(1);
    else if (since_q == SINCE_MAX)
      since_d = since_q;
    else
      since_d = since_q + LINE_W'(1);

    // Only a rise-to-rise span between two real lines is a valid period
    hper_en = (start == LS_REAL) & prev_real_q;
    hper_d  = since_q;

    case (start)
      LS_REAL, LS_TOP: prev_real_d = 1'b1;
      LS_VIRT:         prev_real_d = 1'b0;
      default:         prev_real_d = prev_real_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q     <= '0;
      hper_q      <= HPER_RST;
      prev_real_q <= 1'b0;
    end else begin
      since_q     <= since_d;
      prev_real_q <= prev_real_d;
      if (hper_en)
        hper_q <= hper_d;
    end
  end

  assign since = since_q;
  assign hper  = hper_q;

  AST_PERIOD_SANE: assert property (@(posedge clk) disable iff (!rst_n)
    hper_q != '0); // R5

endmodule

// File: rtl/dfd_raster.sv
module dfd_raster
  import dfd_pkg::*;
#(
  parameter int  H_ACTIVE = 960,
  parameter int  V_ACTIVE = 1080,
  parameter int  LINE_W   = 12,
  localparam int CW       = $clog2(H_ACTIVE + 1),
  localparam int RW       = $clog2(V_ACTIVE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              de,
  input  logic              rise,
  input  logic              top,
  input  logic [LINE_W-1:0] since,
  input  logic [LINE_W-1:0] hper,
  output line_start_e       start,
  output logic [CW-1:0]     cur_col,
  output logic [RW-1:0]     cur_row,
  output logic              lock_now
);

  localparam logic [CW-1:0] COL_END  = CW'(H_ACTIVE);
  localparam logic [RW-1:0] ROW_END  = RW'(V_ACTIVE);
  localparam logic [RW-1:0] ROW_LAST = RW'(V_ACTIVE - 1);

  logic [CW-1:0] col_q, col_d;
  logic [RW-1:0] row_q, row_d;
  logic          locked_q, locked_d;
  logic          virt;

  always_comb begin
    // Missing line: period elapsed with DE low inside an unfinished frame
    virt = locked_q & ~de & (since == hper) & (row_q < ROW_LAST);

    if (top)       start = LS_TOP;
    else if (rise) start = LS_REAL;
    else if (virt) start = LS_VIRT;
    else           start = LS_NONE;

    cur_col = (start == LS_NONE) ? col_q : '0;

    if (top)
      cur_row = '0;
    else if (locked_q && (start == LS_REAL || start == LS_VIRT))
      cur_row = (row_q == ROW_END) ? row_q : row_q + RW'(1);
    else
      cur_row = row_q;

    lock_now = locked_q | top;

    col_d    = (cur_col == COL_END) ? cur_col : cur_col + CW'(1);
    row_d    = cur_row;
    locked_d = lock_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q    <= COL_END;
      row_q    <= ROW_END;
      locked_q <= 1'b0;
    end else begin
      col_q    <= col_d;
      row_q    <= row_d;
      locked_q <= locked_d;
    end
  end

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (de && $past(de) && !rise && $past(cur_col) < COL_END)
      |-> cur_col == $past(cur_col) + CW'(1)); // R1

  AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !top && $past(lock_now) && $past(cur_row) < ROW_END)
      |-> cur_row == $past(cur_row) + RW'(1)); // R6

endmodule

// File: rtl/dfd_frame_locator.sv
module dfd_frame_locator
  import dfd_pkg::*;
#(
  parameter int  H_ACTIVE  = 960,
  parameter int  V_ACTIVE  = 1080,
  parameter int  H_NOMINAL = 1100,
  parameter int  GAP_LINES = 8,
  parameter int  LINE_W    = 12,
  localparam int XW        = $clog2(H_ACTIVE),
  localparam int YW        = $clog2(V_ACTIVE)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_en,
  output logic [XW-1:0] pix_x,
  output logic [YW-1:0] pix_y,
  output logic          pix_valid,
  output logic          fill_black,
  output logic          frame_start
);

  localparam int CW = $clog2(H_ACTIVE + 1);
  localparam int RW = $clog2(V_ACTIVE + 1);
  localparam logic [CW-1:0] COL_END = CW'(H_ACTIVE);
  localparam logic [RW-1:0] ROW_END = RW'(V_ACTIVE);
  localparam logic [XW-1:0] X_LAST  = XW'(H_ACTIVE - 1);
  localparam logic [YW-1:0] Y_LAST  = YW'(V_ACTIVE - 1);

  logic              rise, top, lock_now, in_area;
  logic [LINE_W-1:0] since, hper;
  line_start_e       start;
  logic [CW-1:0]     cur_col;
  logic [RW-1:0]     cur_row;

  dfd_origin_detect #(
    .LINE_W    (LINE_W),
    .GAP_LINES (GAP_LINES)
  ) u_origin (
    .clk   (clk),
    .rst_n (rst_n),
    .de    (data_en),
    .hper  (hper),
    .rise  (rise),
    .top   (top)
  );

  dfd_period_meter #(
    .LINE_W    (LINE_W),
    .H_NOMINAL (H_NOMINAL)
  ) u_period (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .since (since),
    .hper  (hper)
  );

  dfd_raster #(
    .H_ACTIVE (H_ACTIVE),
    .V_ACTIVE (V_ACTIVE),
    .LINE_W   (LINE_W)
  ) u_raster (
    .clk      (clk),
    .rst_n    (rst_n),
    .de       (data_en),
    .rise     (rise),
    .top      (top),
    .since    (since),
    .hper     (hper),
    .start    (start),
    .cur_col  (cur_col),
    .cur_row  (cur_row),
    .lock_now (lock_now)
  );

  always_comb begin
    in_area     = (cur_row < ROW_END) && (cur_col < COL_END);
    pix_valid   = lock_now & data_en & in_area;
    fill_black  = lock_now & ~data_en & in_area;
    frame_start = (start == LS_TOP);
    pix_x       = (cur_col >= COL_END) ? X_LAST : cur_col[XW-1:0];
    pix_y       = (cur_row >= ROW_END) ? Y_LAST : cur_row[YW-1:0];
  end

  AST_FS_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (pix_valid && pix_x == '0 && pix_y == '0)); // R2

  AST_VALID_FILL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && fill_black)); // R3

  AST_X_LEFT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (data_en && !$past(data_en)) |-> pix_x == '0); // R1

  AST_SILENT_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_now |-> (!pix_valid && !fill_black && !frame_start)); // R8

endmodule

// File: tb/tb_dfd_frame_locator.sv
`timescale 1ns/1ps
module tb_dfd_frame_locator;

  localparam int H   = 16;
  localparam int V   = 6;
  localparam int HN  = 24;
  localparam int GAP = 8;
  localparam int LW  = 12;
  localparam int XW  = $clog2(H);
  localparam int YW  = $clog2(V);
  localparam int SINCE_SAT = (1 << LW) - 1;
  localparam int LOW_SAT   = (1 << (LW + $clog2(GAP + 1))) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          data_en = 1'b0;
  logic [XW-1:0] pix_x;
  logic [YW-1:0] pix_y;
  logic          pix_valid, fill_black, frame_start;

  always #10 clk = ~clk;

  dfd_frame_locator #(
    .H_ACTIVE  (H),
    .V_ACTIVE  (V),
    .H_NOMINAL (HN),
    .GAP_LINES (GAP),
    .LINE_W    (LW)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .data_en     (data_en),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .pix_valid   (pix_valid),
    .fill_black  (fill_black),
    .frame_start (frame_start)
  );

  typedef struct {
    bit    v;
    bit    f;
    bit    s;
    int    x;
    int    y;
    string tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad   = 0;

  // Requirement-level model state
  bit m_deq, m_locked, m_prevreal;
  int m_low, m_since, m_hper, m_col, m_row;

  task automatic model_reset();
    m_deq = 0; m_locked = 0; m_prevreal = 0;
    m_low = 0; m_since = 0; m_hper = HN;
    m_col = H; m_row = V;
  endtask

  task automatic model_step(input bit d, input string tag);
    bit   rise, top, virt, st, lk;
    int   col, row;
    exp_t e;
    rise = d && !m_deq;
    top  = rise && (m_low >= GAP * m_hper);                          // R2, R5
    virt = !d && m_locked && (m_since == m_hper) && (m_row < V - 1); // R4
    st   = rise || virt;
    col  = st ? 0 : m_col;
    if (top)                  row = 0;
    else if (st && m_locked)  row = (m_row >= V) ? V : m_row + 1;    // R6
    else                      row = m_row;
    lk    = m_locked || top;
    e.v   = lk && d && row < V && col < H;
    e.f   = lk && !d && row < V && col < H;                          // R3
    e.s   = top;
    e.x   = (col < H) ? col : H - 1;
    e.y   = (row < V) ? row : V - 1;
    e.tag = tag;
    q.push_back(e);
    if (rise && !top && m_prevreal) m_hper = m_since;
    if (rise)      m_prevreal = 1;
    else if (virt) m_prevreal = 0;
    m_since  = st ? 1 : ((m_since < SINCE_SAT) ? m_since + 1 : m_since);
    m_low    = d ? 0 : ((m_low < LOW_SAT) ? m_low + 1 : m_low);
    m_col    = (col < H) ? col + 1 : H;
    m_row    = row;
    m_locked = lk;
    m_deq    = d;
  endtask

  task automatic drive(input bit d, input string tag);
    @(negedge clk);
    data_en = d;
    model_step(d, tag);
  endtask

  task automatic line(input int hi, input int lo, input string tag);
    for (int i = 0; i < hi; i++) drive(1'b1, tag);
    for (int i = 0; i < lo; i++) drive(1'b0, tag);
  endtask

  task automatic lows(input int n, input string tag);
    for (int i = 0; i < n; i++) drive(1'b0, tag);
  endtask

  task automatic check_idle(input string tag);
    total++;
    if (pix_valid || fill_black || frame_start) begin
      bad++;
      $display("FAIL %s: got v=%0b f=%0b s=%0b, want v=0 f=0 s=0",
               tag, pix_valid, fill_black, frame_start);
    end
  endtask

  // Monitor: compare the design against the expected queue each clock
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        total++;
        if (pix_valid !== e.v || fill_black !== e.f || frame_start !== e.s ||
            int'(pix_x) != e.x || int'(pix_y) != e.y) begin
          bad++;
          $display("FAIL %s: got v=%0b f=%0b s=%0b x=%0d y=%0d, want v=%0b f=%0b s=%0b x=%0d y=%0d",
                   e.tag, pix_valid, fill_black, frame_start, pix_x, pix_y,
                   e.v, e.f, e.s, e.x, e.y);
        end
      end
    end
  end

  task automatic run_all();
    // R8: reset state with data_en active
    data_en = 1'b1;
    repeat (3) @(negedge clk);
    #5 check_idle("R8");
    data_en = 1'b0;
    @(posedge clk);
    #3 rst_n = 1'b1;
    model_reset();

    repeat (3) line(16, 8, "R8");           // no lock yet
    lows(200, "R2");                        // gap against nominal period
    line(16, 8, "R2");                      // top line
    repeat (5) line(16, 8, "R1");
    repeat (2) line(16, 8, "R6");           // surplus lines saturate
    lows(150, "R7");                        // below threshold
    repeat (2) line(16, 8, "R7");
    lows(200, "R2");
    repeat (2) line(16, 8, "R3");
    line(10, 14, "R3");                     // truncated pulse
    repeat (3) line(16, 8, "R3");
    lows(300, "R4");
    repeat (3) line(16, 8, "R4");
    lows(250, "R4");                        // synthetic lines 3..5
    repeat (6) line(16, 4, "R5");           // period 20 measured
    lows(166, "R5");                        // run of 170: passes 160, not 192
    line(16, 4, "R5");

    // R9: asynchronous reset in the middle of an active line
    for (int i = 0; i < 5; i++) drive(1'b1, "R9");
    @(negedge clk);
    #7 rst_n = 1'b0;
    #1 check_idle("R9");
    repeat (2) @(posedge clk);
    #1 check_idle("R9");
    data_en = 1'b0;
    @(posedge clk);
    #3 rst_n = 1'b1;
    model_reset();

    repeat (2) line(16, 8, "R8");           // must wait for a new gap
    lows(200, "R2");
    line(16, 8, "R2");
    lows(4, "R3");
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout, want completion");
      end
    join_any
    disable fork;
    repeat (2) @(negedge clk);
    #8;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule